// File: doc/BRIEF.md
# Fault Campaign Controller

This block sits on the debugger side of an on-chip debug link and runs a complete fault injection campaign with no host involvement. Before a campaign, the host writes a script of fixed-width command words into a script memory. A single `run` pulse then starts the sequencer. It steps through the script from entry 0. It can arm a watchpoint in the target's debug unit, wait for an external trigger pin, wait for a watchpoint-hit message, wait for any chosen message, insert a timed delay, and write a memory word. The written value is either a preset value or the value just read back through the debug port with a bit-flip mask applied.

Outgoing debug messages are 40 bits: an 8-bit tag and a 32-bit payload. They are shifted onto a narrow message-in bus of `MDI_W` bits, least-significant chunk first, with a framing strobe. Every message arriving on the 8-bit message-out bus is assembled and appended to a trace memory in arrival order. The host reads that memory back afterwards to reconstruct program flow. When the trace memory fills, further messages are dropped and a sticky overflow flag is raised.

Top module: `fault_campaign_ctrl`

## Requirements
- R1: A command word is {op[67:64], addr[63:32], arg[31:0]}. The opcodes are: 0 end, 1 arm watchpoint, 2 wait external trigger, 3 wait watchpoint hit, 4 wait for tag, 5 delay, 6 write, 7 read, 8 read-flip-write. A `run` pulse while idle or done starts execution at entry 0, and commands run in entry order.
- R2: An outgoing message is 40 bits, with the tag in bits [7:0] and the payload in [39:8]. It is sent `MDI_W` bits per cycle, least-significant chunk first. `mdi_frame` is high on the first and last beat only, and `mdi_frame` and `mdi_data` are 0 when no message is being sent.
- R3: The arm-watchpoint command sends one message with tag 0x11 and payload addr.
- R4: The wait-external-trigger command sends nothing until `ext_trig` is sampled high.
- R5: The wait-watchpoint command continues only after a received message with tag 0x21. A hit received earlier during the same run also releases it.
- R6: The write command sends tag 0x13 with payload addr, then tag 0x14 with payload arg.
- R7: The read and read-flip-write commands send tag 0x12 with payload addr and then wait for a received message with tag 0x22. Read-flip-write then sends tag 0x13 with addr, followed by tag 0x14 with the response payload XOR arg. A plain read sends nothing more.
- R8: The wait-for-tag command continues only after a received message whose tag equals arg[7:0]. Messages with other tags do not release it.
- R9: Suppose a script starts with delay N followed by arm-watchpoint. The first beat of that message appears in the (N+4)th cycle after the cycle in which `run` is high.
- R10: The end opcode, or running past the last script entry, makes `done` high and `busy` low. Both hold until the next `run`.
- R11: A received message is 5 bytes on `mdo_data`, least-significant byte first, with `mdo_valid` per byte and `mdo_frame` on the first and last byte. Each received message is stored at the next trace entry, and the count rises two cycles after its last byte is sampled. `trace_rdata` shows entry `trace_raddr` combinationally.
- R12: With `TRACE_DEPTH` entries stored, further messages are dropped and `trace_ovf` is set and stays set. An accepted `run` clears the count and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scr_we | input | 1 | Script memory write strobe |
| scr_waddr | input | $clog2(SCRIPT_DEPTH) | Script entry to write |
| scr_wdata | input | 68 | Command word to write |
| run | input | 1 | Start pulse, accepted when idle or done |
| ext_trig | input | 1 | External trigger level |
| mdi_data | output | MDI_W | Message-in data chunk toward the debug unit |
| mdi_frame | output | 1 | Framing strobe on first and last beat |
| mdo_data | input | 8 | Message-out byte from the debug unit |
| mdo_valid | input | 1 | Byte valid on mdo_data |
| mdo_frame | input | 1 | Framing strobe on first and last byte |
| trace_raddr | input | $clog2(TRACE_DEPTH) | Trace entry to read |
| trace_rdata | output | 40 | Trace entry contents {payload, tag} |
| trace_count | output | $clog2(TRACE_DEPTH+1) | Number of stored trace entries |
| trace_ovf | output | 1 | Sticky trace overflow flag |
| busy | output | 1 | Script executing |
| done | output | 1 | Script finished |

## Verification
Outgoing messages are rebuilt by a bench monitor at the falling clock edge. The monitor checks the framing of each beat, and the results are compared only after waits sized to cover the message's 20 beats plus the sequencer's fetch cycle. The delay latency is counted exactly, edge by edge, from the cycle `run` is high to the first framed beat (N+4). Trace capture is sampled in the cycle just before and just after its due point, two edges after the last byte, so an extra or missing register stage is caught. Waits for a trigger, a watchpoint hit or a given tag are checked by holding the release condition off for tens of cycles and confirming that nothing is sent.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 8;
    localparam int MSG_W  = TAG_W + DATA_W;
    localparam int MDO_W  = 8;

    typedef enum logic [3:0] {
        OP_END   = 4'd0,
        OP_SETWP = 4'd1,
        OP_WEXT  = 4'd2,
        OP_WWP   = 4'd3,
        OP_WTAG  = 4'd4,
        OP_DELAY = 4'd5,
        OP_WRITE = 4'd6,
        OP_READ  = 4'd7,
        OP_RFW   = 4'd8
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] arg;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef struct packed {
        logic [DATA_W-1:0] payload;
        logic [TAG_W-1:0]  tag;
    } msg_t;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_FETCH, SQ_TX, SQ_WEXT, SQ_WWP,
        SQ_WTAG, SQ_DELAY, SQ_WRD, SQ_DONE
    } seq_e;

    // outgoing tags
    localparam logic [TAG_W-1:0] TAG_WP_CFG  = 8'h11;
    localparam logic [TAG_W-1:0] TAG_RD_REQ  = 8'h12;
    localparam logic [TAG_W-1:0] TAG_WR_ADDR = 8'h13;
    localparam logic [TAG_W-1:0] TAG_WR_DATA = 8'h14;
    // incoming tags
    localparam logic [TAG_W-1:0] TAG_WP_HIT  = 8'h21;
    localparam logic [TAG_W-1:0] TAG_RD_RESP = 8'h22;

    function automatic msg_t mk_msg(logic [TAG_W-1:0] t, logic [DATA_W-1:0] p);
        msg_t m;
        m.tag     = t;
        m.payload = p;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] flip_bits(logic [DATA_W-1:0] v,
                                                    logic [DATA_W-1:0] mask);
        return v ^ mask;
    endfunction

endpackage

// File: rtl/fcc_msg_tx.sv
module fcc_msg_tx
    import fcc_pkg::*;
#(
    parameter int MDI_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  msg_t             msg,
    output logic             busy,
    output logic [MDI_W-1:0] mdi_data,
    output logic             mdi_frame
);
    localparam int NBEATS = MSG_W / MDI_W;
    localparam int BW     = (NBEATS > 1) ? $clog2(NBEATS) : 1;
    localparam logic [BW-1:0] LAST = BW'(NBEATS - 1);

    logic [MSG_W-1:0] shreg;
    logic [BW-1:0]    beat;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            beat   <= '0;
            active <= 1'b0;
        end else if (go && !active) begin
            shreg  <= msg;
            beat   <= '0;
            active <= 1'b1;
        end else if (active) begin
            shreg <= shreg >> MDI_W;
            if (beat == LAST) begin
                beat   <= '0;
                active <= 1'b0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end

    assign busy      = active;
    assign mdi_data  = active ? shreg[MDI_W-1:0] : '0;
    assign mdi_frame = active && ((beat == '0) || (beat == LAST));

endmodule

// File: rtl/fcc_msg_rx.sv
module fcc_msg_rx
    import fcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MDO_W-1:0] mdo_data,
    input  logic             mdo_valid,
    input  logic             mdo_frame,
    output logic             msg_valid,
    output msg_t             msg
);
    localparam int NB = MSG_W / MDO_W;
    localparam int IW = $clog2(NB);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);

    logic [MSG_W-1:0] sh;
    logic [MSG_W-1:0] nxt;
    logic [IW-1:0]    idx;

    assign nxt = {mdo_data, sh[MSG_W-1:MDO_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            idx       <= '0;
            msg_valid <= 1'b0;
            msg       <= '0;
        end else begin
            msg_valid <= 1'b0;
            if (mdo_valid) begin
                sh <= nxt;
                if (idx == LAST) begin
                    msg_valid <= 1'b1;
                    msg       <= msg_t'(nxt);
                    idx       <= '0;
                end else if (mdo_frame) begin
                    idx <= IW'(1);
                end else if (idx != '0) begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fcc_trace_buf.sv
module fcc_trace_buf
    import fcc_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wr,
    input  msg_t                       wdata,
    input  logic [$clog2(DEPTH)-1:0]   raddr,
    output msg_t                       rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    msg_t mem [DEPTH];
    logic full;

    assign full = (count == FULL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (wr) begin
            if (full) ovf <= 1'b1;
            else      count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !clr && !full) mem[count[AW-1:0]] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fault_campaign_ctrl.sv
module fault_campaign_ctrl
    import fcc_pkg::*;
#(
    parameter int MDI_W        = 2,
    parameter int SCRIPT_DEPTH = 16,
    parameter int TRACE_DEPTH  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             scr_we,
    input  logic [$clog2(SCRIPT_DEPTH)-1:0]  scr_waddr,
    input  logic [67:0]                      scr_wdata,
    input  logic                             run,
    input  logic                             ext_trig,
    output logic [MDI_W-1:0]                 mdi_data,
    output logic                             mdi_frame,
    input  logic [7:0]                       mdo_data,
    input  logic                             mdo_valid,
    input  logic                             mdo_frame,
    input  logic [$clog2(TRACE_DEPTH)-1:0]   trace_raddr,
    output logic [39:0]                      trace_rdata,
    output logic [$clog2(TRACE_DEPTH+1)-1:0] trace_count,
    output logic                             trace_ovf,
    output logic                             busy,
    output logic                             done
);
    localparam int SAW = $clog2(SCRIPT_DEPTH);
    localparam int PCW = SAW + 1;
    localparam int TCW = $clog2(TRACE_DEPTH + 1);
    localparam logic [PCW-1:0] PC_END = PCW'(SCRIPT_DEPTH);

    // script store
    logic [CMD_W-1:0] script_mem [SCRIPT_DEPTH];
    always_ff @(posedge clk) begin
        if (scr_we) script_mem[scr_waddr] <= scr_wdata;
    end

    // sequencer state
    seq_e              state, tx_next;
    logic [PCW-1:0]    pc;
    op_e               cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_arg;
    logic [DATA_W-1:0] dly;
    logic [DATA_W-1:0] wr_val;
    logic              pend_wr;
    logic              wp_pend;

    cmd_t  fcmd;
    logic  at_end;
    logic  can_start;
    logic  tx_go, tx_busy;
    msg_t  tx_msg;
    logic  rx_valid;
    msg_t  rx_msg;
    logic  rx_rdresp, rx_wphit;
    msg_t  tr_rdata;

    assign fcmd      = cmd_t'(script_mem[pc[SAW-1:0]]);
    assign at_end    = (pc == PC_END);
    assign can_start = run && (state == SQ_IDLE || state == SQ_DONE);
    assign rx_rdresp = rx_valid && (rx_msg.tag == TAG_RD_RESP);
    assign rx_wphit  = rx_valid && (rx_msg.tag == TAG_WP_HIT);

    // message launch decisions
    always_comb begin
        tx_go  = 1'b0;
        tx_msg = mk_msg('0, '0);
        case (state)
            SQ_FETCH: if (!at_end) begin
                case (fcmd.op)
                    OP_SETWP: begin tx_go = 1'b1; tx_msg = mk_msg(TAG_WP_CFG,  fcmd.addr); end
                    OP_WRITE: begin tx_go = 1'b1; tx_msg = mk_msg(TAG_WR_ADDR, fcmd.addr); end
                    OP_READ,
                    OP_RFW:   begin tx_go = 1'b1; tx_msg = mk_msg(TAG_RD_REQ,  fcmd.addr); end
                    default: ;
                endcase
            end
            SQ_TX: if (!tx_busy && pend_wr) begin
                tx_go  = 1'b1;
                tx_msg = mk_msg(TAG_WR_DATA, wr_val);
            end
            SQ_WRD: if (rx_rdresp && cur_op == OP_RFW) begin
                tx_go  = 1'b1;
                tx_msg = mk_msg(TAG_WR_ADDR, cur_addr);
            end
            default: ;
        endcase
    end

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            tx_next  <= SQ_FETCH;
            pc       <= '0;
            cur_op   <= OP_END;
            cur_addr <= '0;
            cur_arg  <= '0;
            dly      <= '0;
            wr_val   <= '0;
            pend_wr  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE, SQ_DONE: if (run) begin
                    state   <= SQ_FETCH;
                    pc      <= '0;
                    pend_wr <= 1'b0;
                end
                SQ_FETCH: begin
                    if (at_end) begin
                        state <= SQ_DONE;
                    end else begin
                        pc       <= pc + 1'b1;
                        cur_op   <= fcmd.op;
                        cur_addr <= fcmd.addr;
                        cur_arg  <= fcmd.arg;
                        case (fcmd.op)
                            OP_END:   state <= SQ_DONE;
                            OP_SETWP: begin state <= SQ_TX; tx_next <= SQ_FETCH; end
                            OP_WEXT:  state <= SQ_WEXT;
                            OP_WWP:   state <= SQ_WWP;
                            OP_WTAG:  state <= SQ_WTAG;
                            OP_DELAY: begin state <= SQ_DELAY; dly <= fcmd.arg; end
                            OP_WRITE: begin
                                state   <= SQ_TX;
                                tx_next <= SQ_FETCH;
                                pend_wr <= 1'b1;
                                wr_val  <= fcmd.arg;
                            end
                            OP_READ, OP_RFW: begin state <= SQ_TX; tx_next <= SQ_WRD; end
                            default:  state <= SQ_FETCH;
                        endcase
                    end
                end
                SQ_TX: if (!tx_busy) begin
                    if (pend_wr) pend_wr <= 1'b0;
                    else         state   <= tx_next;
                end
                SQ_WEXT:  if (ext_trig) state <= SQ_FETCH;
                SQ_WWP:   if (wp_pend)  state <= SQ_FETCH;
                SQ_WTAG:  if (rx_valid && rx_msg.tag == cur_arg[TAG_W-1:0]) state <= SQ_FETCH;
                SQ_DELAY: begin
                    if (dly == '0) state <= SQ_FETCH;
                    else           dly   <= dly - 1'b1;
                end
                SQ_WRD: if (rx_rdresp) begin
                    if (cur_op == OP_RFW) begin
                        wr_val  <= flip_bits(rx_msg.payload, cur_arg);
                        pend_wr <= 1'b1;
                        state   <= SQ_TX;
                        tx_next <= SQ_FETCH;
                    end else begin
                        state <= SQ_FETCH;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // watchpoint hit memory: set on a hit, consumed by the wait command
    always_ff @(posedge clk) begin
        if (rst || can_start)       wp_pend <= 1'b0;
        else if (rx_wphit)          wp_pend <= 1'b1;
        else if (state == SQ_WWP)   wp_pend <= 1'b0;
    end

    assign busy = (state != SQ_IDLE) && (state != SQ_DONE);
    assign done = (state == SQ_DONE);

    fcc_msg_tx #(.MDI_W(MDI_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .go        (tx_go),
        .msg       (tx_msg),
        .busy      (tx_busy),
        .mdi_data  (mdi_data),
        .mdi_frame (mdi_frame)
    );

    fcc_msg_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .mdo_data  (mdo_data),
        .mdo_valid (mdo_valid),
        .mdo_frame (mdo_frame),
        .msg_valid (rx_valid),
        .msg       (rx_msg)
    );

    fcc_trace_buf #(.DEPTH(TRACE_DEPTH)) u_trace (
        .clk   (clk),
        .rst   (rst),
        .clr   (can_start),
        .wr    (rx_valid),
        .wdata (rx_msg),
        .raddr (trace_raddr),
        .rdata (tr_rdata),
        .count (trace_count),
        .ovf   (trace_ovf)
    );

    assign trace_rdata = tr_rdata;

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int TRACE_DEPTH = 8,
    parameter int TCW         = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic           busy,
    input logic           done,
    input logic           mdi_frame,
    input logic [TCW-1:0] trace_count,
    input logic           trace_ovf
);
    AST_FRAME_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        mdi_frame |-> busy);                                            // R2

    AST_TRACE_CAP: assert property (@(posedge clk) disable iff (rst)
        trace_count <= TCW'(TRACE_DEPTH));                              // R12

    AST_TRACE_STEP: assert property (@(posedge clk) disable iff (rst)
        !run |=> (trace_count == $past(trace_count)) ||
                 (trace_count == $past(trace_count) + TCW'(1)));        // R11

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (trace_ovf && !run) |=> trace_ovf);                             // R12

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !run) |=> done);                                       // R10

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));                                               // R10
endmodule

bind fault_campaign_ctrl fcc_checker #(
    .TRACE_DEPTH (TRACE_DEPTH),
    .TCW         (TCW)
) u_fcc_checker (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .busy        (busy),
    .done        (done),
    .mdi_frame   (mdi_frame),
    .trace_count (trace_count),
    .trace_ovf   (trace_ovf)
);

// File: tb/test_fault_campaign_ctrl.sv
`timescale 1ns/1ps
module test_fault_campaign_ctrl;
    localparam int MDI_W = 2;
    localparam int NB    = 40 / MDI_W;

    localparam logic [3:0] C_END = 4'd0, C_SETWP = 4'd1, C_WEXT = 4'd2, C_WWP = 4'd3,
                           C_WTAG = 4'd4, C_DELAY = 4'd5, C_WRITE = 4'd6,
                           C_READ = 4'd7, C_RFW = 4'd8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scr_we = 1'b0;
    logic [3:0]  scr_waddr = '0;
    logic [67:0] scr_wdata = '0;
    logic        run = 1'b0;
    logic        ext_trig = 1'b0;
    logic [MDI_W-1:0] mdi_data;
    logic        mdi_frame;
    logic [7:0]  mdo_data = '0;
    logic        mdo_valid = 1'b0;
    logic        mdo_frame = 1'b0;
    logic [2:0]  trace_raddr = '0;
    logic [39:0] trace_rdata;
    logic [3:0]  trace_count;
    logic        trace_ovf;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    fault_campaign_ctrl #(.MDI_W(MDI_W), .SCRIPT_DEPTH(16), .TRACE_DEPTH(8)) i_fault_campaign_ctrl (
        .clk(clk), .rst(rst), .scr_we(scr_we), .scr_waddr(scr_waddr), .scr_wdata(scr_wdata),
        .run(run), .ext_trig(ext_trig), .mdi_data(mdi_data), .mdi_frame(mdi_frame),
        .mdo_data(mdo_data), .mdo_valid(mdo_valid), .mdo_frame(mdo_frame),
        .trace_raddr(trace_raddr), .trace_rdata(trace_rdata), .trace_count(trace_count),
        .trace_ovf(trace_ovf), .busy(busy), .done(done)
    );

    // outgoing message monitor
    logic [39:0] sent_q [$];
    logic [39:0] mon_sh;
    int          mon_idx = 0;
    int          frame_err = 0;

    always @(negedge clk) begin
        if (rst) begin
            mon_idx = 0;
        end else if (mon_idx == 0) begin
            if (mdi_frame) begin
                mon_sh = '0;
                mon_sh[MDI_W-1:0] = mdi_data;
                mon_idx = 1;
            end
        end else begin
            mon_sh[mon_idx*MDI_W +: MDI_W] = mdi_data;
            if ((mon_idx == NB-1) != mdi_frame) frame_err++;
            mon_idx++;
            if (mon_idx == NB) begin
                sent_q.push_back(mon_sh);
                mon_idx = 0;
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(int idx, logic [3:0] op, logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        scr_we = 1'b1; scr_waddr = 4'(idx); scr_wdata = {op, a, d};
        @(negedge clk);
        scr_we = 1'b0;
    endtask

    task automatic run_pulse();
        sent_q.delete();
        @(negedge clk); run = 1'b1;
        @(negedge clk); run = 1'b0;
    endtask

    task automatic wait_done(int maxc);
        for (int i = 0; i < maxc && !done; i++) @(negedge clk);
    endtask

    task automatic wait_sent(int n, int maxc);
        for (int i = 0; i < maxc && sent_q.size() < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_mdo(logic [7:0] tag, logic [31:0] pl);
        logic [39:0] m;
        m = {pl, tag};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            mdo_valid = 1'b1;
            mdo_data  = m[i*8 +: 8];
            mdo_frame = (i == 0) || (i == 4);
        end
        @(negedge clk);
        mdo_valid = 1'b0; mdo_frame = 1'b0; mdo_data = '0;
    endtask

    task automatic t_reset();
        chk("R10 busy after reset", 64'(busy), 64'd0);
        chk("R10 done after reset", 64'(done), 64'd0);
        chk("R2 frame idle", 64'(mdi_frame), 64'd0);
        chk("R2 data idle", 64'(mdi_data), 64'd0);
        chk("R12 count after reset", 64'(trace_count), 64'd0);
        chk("R12 ovf after reset", 64'(trace_ovf), 64'd0);
    endtask

    task automatic t_write_predet();
        put(0, C_WEXT, 0, 0);
        put(1, C_WRITE, 32'h1000_0040, 32'hA5A5_0F0F);
        put(2, C_END, 0, 0);
        run_pulse();
        repeat (30) @(negedge clk);
        chk("R4 nothing sent before trigger", 64'(sent_q.size()), 64'd0);
        chk("R1 busy while waiting", 64'(busy), 64'd1);
        ext_trig = 1'b1;
        wait_done(300);
        ext_trig = 1'b0;
        chk("R6 two messages", 64'(sent_q.size()), 64'd2);
        if (sent_q.size() >= 2) begin
            chk("R6 address message", 64'(sent_q[0]), 64'({32'h1000_0040, 8'h13}));
            chk("R6 data message", 64'(sent_q[1]), 64'({32'hA5A5_0F0F, 8'h14}));
        end
        chk("R2 framing", 64'(frame_err), 64'd0);
        chk("R10 done after end", 64'(done), 64'd1);
    endtask

    task automatic t_watchpoint();
        put(0, C_SETWP, 32'h2000_0010, 0);
        put(1, C_WWP, 0, 0);
        put(2, C_WRITE, 32'h0000_0030, 32'h0000_0001);
        put(3, C_END, 0, 0);
        run_pulse();
        wait_sent(1, 200);
        chk("R3 arm message", 64'(sent_q.size() > 0 ? sent_q[0] : 40'h0), 64'({32'h2000_0010, 8'h11}));
        repeat (60) @(negedge clk);
        chk("R5 held before hit", 64'(sent_q.size()), 64'd1);
        send_mdo(8'h21, 32'h0000_DEAD);
        wait_done(300);
        chk("R5 released by hit", 64'(sent_q.size()), 64'd3);
        if (sent_q.size() >= 3)
            chk("R5 write after hit", 64'(sent_q[1]), 64'({32'h0000_0030, 8'h13}));
        trace_raddr = 3'd0;
        @(negedge clk);
        chk("R11 hit stored in trace", 64'(trace_rdata), 64'({32'h0000_DEAD, 8'h21}));
        chk("R11 one entry", 64'(trace_count), 64'd1);
        // hit arriving before the wait command is remembered
        put(0, C_DELAY, 0, 32'd40);
        put(1, C_WWP, 0, 0);
        put(2, C_SETWP, 32'h0000_0007, 0);
        put(3, C_END, 0, 0);
        run_pulse();
        send_mdo(8'h21, 32'h0);
        wait_done(300);
        chk("R5 early hit remembered", 64'(sent_q.size()), 64'd1);
        if (sent_q.size() >= 1)
            chk("R5 message after early hit", 64'(sent_q[0]), 64'({32'h0000_0007, 8'h11}));
    endtask

    task automatic t_read_flip();
        put(0, C_RFW, 32'h4000_0000, 32'h0000_0100);
        put(1, C_END, 0, 0);
        run_pulse();
        wait_sent(1, 200);
        chk("R7 read request", 64'(sent_q.size() > 0 ? sent_q[0] : 40'h0), 64'({32'h4000_0000, 8'h12}));
        repeat (20) @(negedge clk);
        chk("R7 waits for response", 64'(sent_q.size()), 64'd1);
        send_mdo(8'h22, 32'h1234_5678);
        wait_done(300);
        chk("R7 rfw message count", 64'(sent_q.size()), 64'd3);
        if (sent_q.size() >= 3) begin
            chk("R7 rfw address", 64'(sent_q[1]), 64'({32'h4000_0000, 8'h13}));
            chk("R7 rfw flipped data", 64'(sent_q[2]), 64'({32'h1234_5778, 8'h14}));
        end
        put(0, C_READ, 32'h0000_0044, 0);
        put(1, C_SETWP, 32'h0000_0009, 0);
        put(2, C_END, 0, 0);
        run_pulse();
        wait_sent(1, 200);
        send_mdo(8'h22, 32'h0000_CAFE);
        wait_done(300);
        chk("R7 plain read sends no write", 64'(sent_q.size()), 64'd2);
        if (sent_q.size() >= 2)
            chk("R7 next command after read", 64'(sent_q[1]), 64'({32'h0000_0009, 8'h11}));
    endtask

    task automatic t_wait_tag();
        put(0, C_WTAG, 0, 32'h0000_0033);
        put(1, C_SETWP, 32'h0000_0005, 0);
        put(2, C_END, 0, 0);
        run_pulse();
        send_mdo(8'h44, 32'h1);
        repeat (30) @(negedge clk);
        chk("R8 other tag ignored", 64'(sent_q.size()), 64'd0);
        chk("R8 still busy", 64'(busy), 64'd1);
        send_mdo(8'h33, 32'h2);
        wait_done(300);
        chk("R8 matching tag releases", 64'(sent_q.size()), 64'd1);
    endtask

    task automatic t_delay(int n);
        int cnt;
        put(0, C_DELAY, 0, 32'(n));
        put(1, C_SETWP, 32'h0000_0001, 0);
        put(2, C_END, 0, 0);
        run_pulse();
        cnt = 1;
        while (!mdi_frame && cnt < 500) begin
            @(negedge clk);
            cnt++;
        end
        chk($sformatf("R9 delay %0d latency", n), 64'(cnt), 64'(n + 4));
        wait_done(300);
    endtask

    task automatic t_exhaust();
        for (int i = 0; i < 16; i++) put(i, C_DELAY, 0, 0);
        run_pulse();
        wait_done(300);
        chk("R10 done on exhausted script", 64'(done), 64'd1);
        chk("R10 not busy", 64'(busy), 64'd0);
        chk("R1 no messages", 64'(sent_q.size()), 64'd0);
        repeat (5) @(negedge clk);
        chk("R10 done holds", 64'(done), 64'd1);
    endtask

    task automatic t_trace();
        put(0, C_END, 0, 0);
        run_pulse();
        wait_done(50);
        chk("R12 run clears trace", 64'(trace_count), 64'd0);
        for (int i = 0; i < 3; i++) send_mdo(8'(8'h50 + i), 32'(i * 32'h111));
        chk("R11 count not yet updated", 64'(trace_count), 64'd2);
        @(negedge clk);
        chk("R11 count due two edges after last byte", 64'(trace_count), 64'd3);
        for (int i = 3; i < 10; i++) send_mdo(8'(8'h50 + i), 32'(i * 32'h111));
        repeat (3) @(negedge clk);
        chk("R12 count saturates", 64'(trace_count), 64'd8);
        chk("R12 overflow set", 64'(trace_ovf), 64'd1);
        trace_raddr = 3'd0;
        @(negedge clk);
        chk("R11 first entry", 64'(trace_rdata), 64'({32'h0, 8'h50}));
        trace_raddr = 3'd7;
        @(negedge clk);
        chk("R12 last kept entry", 64'(trace_rdata), 64'({32'(7 * 32'h111), 8'h57}));
        repeat (5) @(negedge clk);
        chk("R12 overflow sticky", 64'(trace_ovf), 64'd1);
        run_pulse();
        wait_done(50);
        chk("R12 run clears overflow", 64'(trace_ovf), 64'd0);
        chk("R12 run clears count", 64'(trace_count), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_predet();
        t_watchpoint();
        t_read_flip();
        t_wait_tag();
        t_delay(0);
        t_delay(7);
        t_trace();
        t_exhaust();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule